// File: doc/BRIEF.md
# Low-Power Stop and Freeze Mode Controller

This block sits in a microcontroller's system integration logic. It decides, cycle by cycle, which clock enables reach the software watchdog, the periodic interrupt timer, the bus monitor, the double bus fault monitor, the spurious interrupt monitor and each peripheral module's core logic. Its inputs are a request to enter low-power stop, a plain-stop indication, a debug freeze input, an external halt input, per-function freeze enable bits, per-module stop bits, and the periodic timer's status and interrupt request.

A low-power-stop request waits while halt is held and is remembered until halt drops. While low-power stop is active, the watchdog and the three bus monitors lose their clocks. The periodic timer keeps running unless its reload value was zero when the stop began. A timer interrupt whose level is above the core's mask level ends the stop and emits a one-cycle wake pulse. Mode state changes on the rising clock edge. Every clock enable changes only on the falling edge, so a gate downstream never sees a change while the clock is high.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A synchronous reset clears the low-power-stop state, any pending request and the wake pulse. After the next falling edge it drives every clock enable, including every module enable, to 1.
- R2: The plain-stop input has no effect on any output. In particular, the watchdog enable stays 1.
- R3: While low-power stop is active, the watchdog, bus monitor, double bus fault monitor and spurious interrupt monitor enables are 0.
- R4: During low-power stop, the timer enable stays 1 if the reload-zero input was 0 at entry, and is 0 if it was 1 at entry.
- R5: During low-power stop with the timer running, an interrupt request whose level is numerically greater than the mask level clears the stop on the next rising edge and raises the wake pulse for exactly one cycle. A level equal to or below the mask does not wake. A halted timer never wakes.
- R6: Entry into low-power stop does not happen while halt is 1. A request made during halt is held and taken on the first rising edge where halt is 0.
- R7: While freeze is 1, freeze-enable bit 0 clears the watchdog enable, bit 1 clears the timer enable and bit 2 clears the bus monitor enable. The double bus fault and spurious interrupt monitor enables are unaffected. With freeze at 0 the bits have no effect.
- R8: Module stop bit i clears module enable i only. Clearing the bit restores it.
- R9: Clock enables change only on the falling clock edge. A change caused by an input or state update at a rising edge is not visible until the following falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_req | input | 1 | Request to enter low-power stop |
| plain_stop | input | 1 | Ordinary stop indication (no gating effect) |
| freeze | input | 1 | Debug freeze |
| halt_in | input | 1 | External halt, postpones low-power entry |
| frz_sel | input | 3 | Freeze enables: bit0 watchdog, bit1 timer, bit2 bus monitor |
| mod_stop | input | NMOD | Per-module stop bits |
| pit_reload_zero | input | 1 | Timer reload value is zero |
| pit_irq | input | 1 | Timer interrupt request |
| pit_lvl | input | LVL_W | Timer interrupt level |
| core_mask | input | LVL_W | Core interrupt mask level |
| wdog_en | output | 1 | Watchdog clock enable |
| pit_en | output | 1 | Periodic timer clock enable |
| busmon_en | output | 1 | Bus monitor enable |
| dbf_en | output | 1 | Double bus fault monitor enable |
| spur_en | output | 1 | Spurious interrupt monitor enable |
| mod_en | output | NMOD | Per-module core clock enables |
| lp_active | output | 1 | Low-power stop in effect |
| wake_pulse | output | 1 | One-cycle pulse when a timer interrupt ends the stop |

## Verification
The bench builds the block with three modules and a three-bit interrupt level. Three modules allow stop patterns where a cleared bit sits between set bits, and the reverse. The three-bit level allows a level both below and above a mid-range mask, and a maximum level against a zero mask for the halted-timer case. The freeze enable bits are exercised one at a time and all together, and checks are sampled on both sides of a falling edge to show that enables move only there.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
    localparam int FRZ_W    = 3;
    localparam int FRZ_WDOG = 0;
    localparam int FRZ_PIT  = 1;
    localparam int FRZ_BMON = 2;

    typedef struct packed {
        logic wdog;
        logic pit;
        logic busmon;
        logic dbf;
        logic spur;
    } mon_en_t;

    localparam mon_en_t ALL_ON = '{wdog: 1'b1, pit: 1'b1, busmon: 1'b1, dbf: 1'b1, spur: 1'b1};

    function automatic logic level_beats(input logic [7:0] lvl, input logic [7:0] mask);
        return lvl > mask;
    endfunction
endpackage

// File: rtl/lp_seq.sv
module lp_seq #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lp_req,
    input  logic             halt_in,
    input  logic             pit_reload_zero,
    input  logic             pit_irq,
    input  logic [LVL_W-1:0] pit_lvl,
    input  logic [LVL_W-1:0] core_mask,
    output logic             lp_active,
    output logic             pit_hold,
    output logic             wake_pulse
);
    import pwr_mode_pkg::*;

    logic pend;
    logic wake_now;

    always_comb begin
        wake_now = lp_active && !pit_hold && pit_irq &&
                   level_beats(8'(pit_lvl), 8'(core_mask));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lp_active  <= 1'b0;
            pit_hold   <= 1'b0;
            pend       <= 1'b0;
            wake_pulse <= 1'b0;
        end else begin
            wake_pulse <= 1'b0;
            if (lp_active) begin
                if (wake_now) begin
                    lp_active  <= 1'b0;
                    pit_hold   <= 1'b0;
                    wake_pulse <= 1'b1;
                end
            end else if ((lp_req || pend) && !halt_in) begin
                lp_active <= 1'b1;
                pend      <= 1'b0;
                pit_hold  <= pit_reload_zero;
            end else if (lp_req) begin
                pend <= 1'b1;
            end
        end
    end

    // R6
    halt_blocks_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (halt_in && !lp_active) |=> !lp_active);
    // R5
    wake_single_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);
    // R5
    wake_clears_stop_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> !lp_active);
endmodule

// File: rtl/clk_gate_stage.sv
module clk_gate_stage #(
    parameter int NMOD = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          lp_active,
    input  logic                          pit_hold,
    input  logic                          freeze,
    input  logic [pwr_mode_pkg::FRZ_W-1:0] frz_sel,
    input  logic [NMOD-1:0]               mod_stop,
    output pwr_mode_pkg::mon_en_t         mon_en,
    output logic [NMOD-1:0]               mod_en
);
    import pwr_mode_pkg::*;

    mon_en_t nxt;

    always_comb begin
        nxt.wdog   = !lp_active && !(freeze && frz_sel[FRZ_WDOG]);
        nxt.pit    = !(lp_active && pit_hold) && !(freeze && frz_sel[FRZ_PIT]);
        nxt.busmon = !lp_active && !(freeze && frz_sel[FRZ_BMON]);
        nxt.dbf    = !lp_active;
        nxt.spur   = !lp_active;
    end

    always_ff @(negedge clk) begin
        if (rst) mon_en <= ALL_ON;
        else     mon_en <= nxt;
    end

    for (genvar i = 0; i < NMOD; i++) begin : g_mod
        always_ff @(negedge clk) begin
            if (rst) mod_en[i] <= 1'b1;
            else     mod_en[i] <= !mod_stop[i];
        end
    end

    // R3
    lp_mon_off_chk: assert property (@(posedge clk) disable iff (rst)
        lp_active |-> (!mon_en.wdog && !mon_en.busmon && !mon_en.dbf && !mon_en.spur));
    // R7
    frz_keeps_dbf_chk: assert property (@(posedge clk) disable iff (rst)
        (freeze && !lp_active) |-> (mon_en.dbf && mon_en.spur));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
    parameter int NMOD  = 4,
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lp_req,
    input  logic             plain_stop,
    input  logic             freeze,
    input  logic             halt_in,
    input  logic [2:0]       frz_sel,
    input  logic [NMOD-1:0]  mod_stop,
    input  logic             pit_reload_zero,
    input  logic             pit_irq,
    input  logic [LVL_W-1:0] pit_lvl,
    input  logic [LVL_W-1:0] core_mask,
    output logic             wdog_en,
    output logic             pit_en,
    output logic             busmon_en,
    output logic             dbf_en,
    output logic             spur_en,
    output logic [NMOD-1:0]  mod_en,
    output logic             lp_active,
    output logic             wake_pulse
);
    import pwr_mode_pkg::*;

    logic    pit_hold;
    mon_en_t mon_en;
    logic    unused_stop;

    assign unused_stop = plain_stop;

    lp_seq #(.LVL_W(LVL_W)) u_seq (
        .clk(clk), .rst(rst), .lp_req(lp_req), .halt_in(halt_in),
        .pit_reload_zero(pit_reload_zero), .pit_irq(pit_irq),
        .pit_lvl(pit_lvl), .core_mask(core_mask),
        .lp_active(lp_active), .pit_hold(pit_hold), .wake_pulse(wake_pulse)
    );

    clk_gate_stage #(.NMOD(NMOD)) u_gate (
        .clk(clk), .rst(rst), .lp_active(lp_active), .pit_hold(pit_hold),
        .freeze(freeze), .frz_sel(frz_sel), .mod_stop(mod_stop),
        .mon_en(mon_en), .mod_en(mod_en)
    );

    assign wdog_en   = mon_en.wdog;
    assign pit_en    = mon_en.pit;
    assign busmon_en = mon_en.busmon;
    assign dbf_en    = mon_en.dbf;
    assign spur_en   = mon_en.spur;

    // R2
    plain_stop_wdog_chk: assert property (@(posedge clk) disable iff (rst)
        (plain_stop && !lp_active && !freeze) |-> wdog_en);
endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
    localparam int NMOD  = 3;
    localparam int LVL_W = 3;
    localparam int NVEC  = 10;

    // {freeze, frz_sel[2:0], mod_stop[2:0], plain_stop, wdog, pit, busmon, dbf, spur, mod_en[2:0]}
    localparam logic [15:0] VECS [NVEC] = '{
        16'b0_000_000_0_11111_111,
        16'b0_000_000_1_11111_111,
        16'b1_000_000_0_11111_111,
        16'b1_001_000_0_01111_111,
        16'b1_010_000_0_10111_111,
        16'b1_100_000_0_11011_111,
        16'b1_111_000_1_00011_111,
        16'b0_111_000_0_11111_111,
        16'b0_000_101_0_11111_010,
        16'b0_000_010_1_11111_101
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lp_req = 0, plain_stop = 0, freeze = 0, halt_in = 0;
    logic [2:0] frz_sel = 0;
    logic [NMOD-1:0] mod_stop = 0;
    logic pit_reload_zero = 0, pit_irq = 0;
    logic [LVL_W-1:0] pit_lvl = 0, core_mask = 0;
    logic wdog_en, pit_en, busmon_en, dbf_en, spur_en, lp_active, wake_pulse;
    logic [NMOD-1:0] mod_en;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pwr_mode_ctrl #(.NMOD(NMOD), .LVL_W(LVL_W)) uut (
        .clk(clk), .rst(rst), .lp_req(lp_req), .plain_stop(plain_stop),
        .freeze(freeze), .halt_in(halt_in), .frz_sel(frz_sel), .mod_stop(mod_stop),
        .pit_reload_zero(pit_reload_zero), .pit_irq(pit_irq), .pit_lvl(pit_lvl),
        .core_mask(core_mask), .wdog_en(wdog_en), .pit_en(pit_en),
        .busmon_en(busmon_en), .dbf_en(dbf_en), .spur_en(spur_en),
        .mod_en(mod_en), .lp_active(lp_active), .wake_pulse(wake_pulse)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin
        for (int w = 0; w < 5000; w++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(); tick(); tick();
        rst = 0;
        // R1 reset state
        chk("R1 mon", {wdog_en, pit_en, busmon_en, dbf_en, spur_en}, 5'b11111);
        chk("R1 mod", mod_en, 3'b111);
        chk("R1 state", {lp_active, wake_pulse}, 2'b00);

        // R2/R7/R8 vector walk
        for (int v = 0; v < NVEC; v++) begin
            {freeze, frz_sel, mod_stop, plain_stop} = VECS[v][15:8];
            tick(); tick();
            chk($sformatf("R2/R7/R8 vec %0d mon", v),
                {wdog_en, pit_en, busmon_en, dbf_en, spur_en}, VECS[v][7:3]);
            chk($sformatf("R2/R7/R8 vec %0d mod", v), mod_en, VECS[v][2:0]);
        end
        {freeze, frz_sel, mod_stop, plain_stop} = '0;
        tick(); tick();

        // R6 halt postpones entry, request remembered
        halt_in = 1; lp_req = 1;
        tick();
        lp_req = 0;
        tick(); tick();
        chk("R6 held", lp_active, 1'b0);
        halt_in = 0;
        tick();
        chk("R6 entered", lp_active, 1'b1);
        // R9 enables not yet changed before falling edge
        chk("R9 before fall", wdog_en, 1'b1);
        #4;
        chk("R9 after fall", wdog_en, 1'b0);
        tick();
        // R3 and R4
        chk("R3 mons off", {wdog_en, busmon_en, dbf_en, spur_en}, 4'b0000);
        chk("R4 pit runs", pit_en, 1'b1);

        // R5 level not above mask: no wake
        pit_irq = 1; pit_lvl = 3'd2; core_mask = 3'd3;
        tick(); tick();
        chk("R5 low level", {lp_active, wake_pulse}, 2'b10);
        pit_lvl = 3'd3;
        tick(); tick();
        chk("R5 equal level", {lp_active, wake_pulse}, 2'b10);
        pit_lvl = 3'd5;
        tick();
        chk("R5 wake", {lp_active, wake_pulse}, 2'b01);
        pit_irq = 0;
        tick();
        chk("R5 pulse width", wake_pulse, 1'b0);
        chk("R3 restored", {wdog_en, busmon_en, dbf_en, spur_en}, 4'b1111);

        // R4 reload zero halts timer; R5 halted timer cannot wake
        pit_reload_zero = 1; lp_req = 1;
        tick();
        lp_req = 0; pit_reload_zero = 0;
        tick();
        chk("R4 pit halted", pit_en, 1'b0);
        pit_irq = 1; pit_lvl = 3'd7; core_mask = 3'd0;
        tick(); tick();
        chk("R5 halted no wake", {lp_active, wake_pulse}, 2'b10);

        // R1 reset leaves stop
        rst = 1;
        tick(); tick();
        rst = 0; pit_irq = 0;
        chk("R1 reset clears", {lp_active, wake_pulse}, 2'b00);
        chk("R1 reset enables", {wdog_en, pit_en, busmon_en, dbf_en, spur_en, mod_en}, 8'hFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule